// File: doc/BRIEF.md
# Delayed-Transaction Bus Target

This block is a bus target whose backing storage sits behind a slow internal port, too slow to answer within the bus response deadline. It does not stall the bus with wait states. On the first attempt of a slow read or a non-posted slow write, it records the request, answers with retry, and then performs the access on the internal port. The initiator is expected to issue the same request again later. When a repeat arrives that is identical in command, address, byte enables and (for writes) write data, the target completes it with the buffered result. Any initiator that presents an identical request may collect that result.

Only one delayed transaction is held at a time. While that slot is occupied, any other slow request is retried and not recorded. Fast commands address a small local register bank and complete at once, whatever the state of the slot. A discard timer releases a buffered result that nobody collects, so a lost initiator cannot block the target forever.

The bus handshake is reduced to a one-cycle request. Exactly one response flag (complete or retry) follows it one clock later. The internal port uses a start pulse and a done pulse. The number of cycles between the two is set by whatever sits behind the port.

Top module: `dtgt_top`

## Requirements
- R1: A slow request (reqCmd 2'b00 = slow read, 2'b01 = slow write) that arrives while the slot is empty is recorded. One cycle later it is answered with rspRetry=1 and rspAck=0, and in that same cycle intStart pulses for one cycle. intWrite equals reqCmd[0], and intAddr, intBe and intWdata equal the request's fields.
- R2: intWrite, intAddr, intBe and intWdata present the recorded request and change only when a new request is recorded. All four are 0 after reset.
- R3: An intDone pulse while the internal access is outstanding captures intRdata as the buffered result. An intDone pulse at any other time is ignored, and the buffered result keeps its value.
- R4: A slow request that matches the buffered request is answered one cycle later with rspAck=1. rspData carries the buffered read data for a slow read and 0 for a slow write. The slot is then empty again, so the next slow request is recorded.
- R5: A request matches only if its command, address and byte enables all equal the recorded ones. For a slow write the write data must also be equal. For a slow read the write data is not compared.
- R6: While the slot holds a request, a slow request is answered with retry and is neither recorded nor started. This covers an identical request made before intDone and any non-matching request after it.
- R7: Fast commands (reqCmd 2'b10 = register read, 2'b11 = register write) select register reqAddr[1:0] of a 4-entry bank and are answered one cycle later with rspAck=1, in any slot state. A register write updates only the byte lanes whose reqBe bit is 1 (bit i covers data bits 8i+7..8i). A register read returns the whole register on rspData.
- R8: If no matching request arrives within DISCARD_CYCLES cycles after the result is buffered, the slot is emptied. The latest cycle in which a matching request is still served is the DISCARD_CYCLES-th cycle after capture. The next slow request is then recorded anew.
- R9: Every cycle with reqValid=1 is followed one cycle later by exactly one of rspAck and rspRetry. A cycle without reqValid is followed by neither, and rspData is 0 whenever rspAck is 0.
- R10: After reset, every output is 0 and the slot is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqCmd | input | 2 | Command: 00 slow read, 01 slow write, 10 register read, 11 register write |
| reqAddr | input | ADDR_W | Request address |
| reqBe | input | DATA_W/8 | Byte enables |
| reqWdata | input | DATA_W | Write data |
| rspAck | output | 1 | Request completed (one cycle after request) |
| rspRetry | output | 1 | Request must be repeated (one cycle after request) |
| rspData | output | DATA_W | Read data accompanying rspAck |
| intStart | output | 1 | Internal access start pulse |
| intWrite | output | 1 | Internal access is a write |
| intAddr | output | ADDR_W | Internal access address |
| intBe | output | DATA_W/8 | Internal access byte enables |
| intWdata | output | DATA_W | Internal access write data |
| intDone | input | 1 | Internal access completion pulse |
| intRdata | input | DATA_W | Internal read data, valid with intDone |

## Verification
The bench builds the block with ADDR_W=16, DATA_W=32 and FAST_REGS=4, and lowers DISCARD_CYCLES to 40. At that value the discard path and the re-recording that follows it are reached in a short run. The internal port's latency is a bench variable. It is set to 12 cycles, so repeats land while the access is still outstanding. It is then set to 3 cycles, so repeats land after the result is buffered. A stray completion pulse is also injected into the buffered state to show that it is ignored.

// File: rtl/dtgt_pkg.sv
package dtgt_pkg;

  typedef enum logic [1:0] {
    CMD_SLOW_RD = 2'b00,
    CMD_SLOW_WR = 2'b01,
    CMD_FAST_RD = 2'b10,
    CMD_FAST_WR = 2'b11
  } cmd_e;

  typedef enum logic [1:0] {
    SLOT_EMPTY = 2'd0,
    SLOT_BUSY  = 2'd1,
    SLOT_READY = 2'd2
  } slot_e;

  typedef struct packed {
    logic record;   // latch request, launch internal access
    logic capture;  // latch internal read data
    logic deliver;  // complete a matching repeat
    logic fastRd;   // register bank read
    logic fastWr;   // register bank write
  } strobes_t;

endpackage

// File: rtl/dtgt_ctrl.sv
module dtgt_ctrl
  import dtgt_pkg::*;
#(
  parameter int DISCARD_CYCLES = 1024
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic [1:0] reqCmd,
  input  logic     reqMatch,
  input  logic     intDone,
  output strobes_t str,
  output logic     rspAck,
  output logic     rspRetry,
  output logic     intStart
);

  localparam int TMR_W = (DISCARD_CYCLES > 1) ? $clog2(DISCARD_CYCLES) : 1;
  localparam logic [TMR_W-1:0] AGE_LAST = TMR_W'(DISCARD_CYCLES - 1);

  slot_e            state, stateNxt;
  logic [TMR_W-1:0] age;
  logic             slowReq, fastReq;

  assign slowReq = reqValid && !reqCmd[1];
  assign fastReq = reqValid &&  reqCmd[1];

  always_comb begin
    str         = '0;
    str.fastRd  = fastReq && !reqCmd[0];
    str.fastWr  = fastReq &&  reqCmd[0];
    str.record  = slowReq && (state == SLOT_EMPTY);
    str.deliver = slowReq && (state == SLOT_READY) && reqMatch;
    str.capture = (state == SLOT_BUSY) && intDone;
  end

  always_comb begin
    stateNxt = state;
    unique case (state)
      SLOT_EMPTY: if (str.record) stateNxt = SLOT_BUSY;
      SLOT_BUSY:  if (str.capture) stateNxt = SLOT_READY;
      SLOT_READY: if (str.deliver || (age == AGE_LAST)) stateNxt = SLOT_EMPTY;
      default:    stateNxt = SLOT_EMPTY;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= SLOT_EMPTY;
      age      <= '0;
      rspAck   <= 1'b0;
      rspRetry <= 1'b0;
      intStart <= 1'b0;
    end else begin
      state    <= stateNxt;
      if (state == SLOT_READY && stateNxt == SLOT_READY) age <= age + 1'b1;
      else                                               age <= '0;
      rspAck   <= fastReq || str.deliver;
      rspRetry <= slowReq && !str.deliver;
      intStart <= str.record;
    end
  end

  // R9: each request yields exactly one response flag a cycle later
  assert_one_response_R9: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (rspAck ^ rspRetry));
  // R9: silence follows an idle cycle
  assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!rspAck && !rspRetry));
  // R1: the internal start is a single-cycle pulse
  assert_start_pulse_R1: assert property (@(posedge clk) disable iff (!rstN)
    intStart |=> !intStart);
  // R6: nothing is launched while the slot is held
  assert_no_start_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state != SLOT_EMPTY) |=> !intStart);
  // R6: a slow request during the outstanding access is retried
  assert_busy_retry_R6: assert property (@(posedge clk) disable iff (!rstN)
    (slowReq && state == SLOT_BUSY) |=> (rspRetry && !intStart));
  // R8: the discard counter never runs past its limit
  assert_age_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    age <= AGE_LAST);

endmodule

// File: rtl/dtgt_dpath.sv
module dtgt_dpath
  import dtgt_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int FAST_REGS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobes_t            str,
  input  logic [1:0]          reqCmd,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W/8-1:0] reqBe,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [DATA_W-1:0]   intRdata,
  output logic                reqMatch,
  output logic [DATA_W-1:0]   rspData,
  output logic                intWrite,
  output logic [ADDR_W-1:0]   intAddr,
  output logic [DATA_W/8-1:0] intBe,
  output logic [DATA_W-1:0]   intWdata
);

  localparam int BE_W   = DATA_W / 8;
  localparam int FIDX_W = (FAST_REGS > 1) ? $clog2(FAST_REGS) : 1;

  logic [1:0]        recCmd;
  logic [ADDR_W-1:0] recAddr;
  logic [BE_W-1:0]   recBe;
  logic [DATA_W-1:0] recWdata;
  logic [DATA_W-1:0] bufData;
  logic [DATA_W-1:0] fastReg [FAST_REGS];
  logic [FIDX_W-1:0] fIdx;
  logic [DATA_W-1:0] mergedWr;
  logic              dataEq;

  assign fIdx = reqAddr[FIDX_W-1:0];

  // Byte-lane merge for register writes
  for (genvar b = 0; b < BE_W; b++) begin : g_lane
    assign mergedWr[b*8 +: 8] = reqBe[b] ? reqWdata[b*8 +: 8] : fastReg[fIdx][b*8 +: 8];
  end

  assign dataEq   = (recCmd != CMD_SLOW_WR) || (reqWdata == recWdata);
  assign reqMatch = (reqCmd == recCmd) && (reqAddr == recAddr) &&
                    (reqBe == recBe) && dataEq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      recCmd   <= '0;
      recAddr  <= '0;
      recBe    <= '0;
      recWdata <= '0;
      bufData  <= '0;
      rspData  <= '0;
      for (int r = 0; r < FAST_REGS; r++) fastReg[r] <= '0;
    end else begin
      if (str.record) begin
        recCmd   <= reqCmd;
        recAddr  <= reqAddr;
        recBe    <= reqBe;
        recWdata <= reqWdata;
      end
      if (str.capture) bufData <= intRdata;
      if (str.fastWr) fastReg[fIdx] <= mergedWr;
      if (str.deliver)     rspData <= (recCmd == CMD_SLOW_WR) ? '0 : bufData;
      else if (str.fastRd) rspData <= fastReg[fIdx];
      else                 rspData <= '0;
    end
  end

  assign intWrite = recCmd[0];
  assign intAddr  = recAddr;
  assign intBe    = recBe;
  assign intWdata = recWdata;

  // R2: recorded request only changes on a new record
  assert_rec_stable_R2: assert property (@(posedge clk) disable iff (!rstN)
    !str.record |=> $stable({recCmd, recAddr, recBe, recWdata}));
  // R3: buffered result only changes on a capture
  assert_buf_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    !str.capture |=> $stable(bufData));

endmodule

// File: rtl/dtgt_top.sv
module dtgt_top
  import dtgt_pkg::*;
#(
  parameter int ADDR_W         = 16,
  parameter int DATA_W         = 32,
  parameter int FAST_REGS      = 4,
  parameter int DISCARD_CYCLES = 1024
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [1:0]          reqCmd,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W/8-1:0] reqBe,
  input  logic [DATA_W-1:0]   reqWdata,
  output logic                rspAck,
  output logic                rspRetry,
  output logic [DATA_W-1:0]   rspData,
  output logic                intStart,
  output logic                intWrite,
  output logic [ADDR_W-1:0]   intAddr,
  output logic [DATA_W/8-1:0] intBe,
  output logic [DATA_W-1:0]   intWdata,
  input  logic                intDone,
  input  logic [DATA_W-1:0]   intRdata
);

  strobes_t str;
  logic     reqMatch;

  dtgt_ctrl #(.DISCARD_CYCLES(DISCARD_CYCLES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqCmd   (reqCmd),
    .reqMatch (reqMatch),
    .intDone  (intDone),
    .str      (str),
    .rspAck   (rspAck),
    .rspRetry (rspRetry),
    .intStart (intStart)
  );

  dtgt_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FAST_REGS(FAST_REGS)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .str      (str),
    .reqCmd   (reqCmd),
    .reqAddr  (reqAddr),
    .reqBe    (reqBe),
    .reqWdata (reqWdata),
    .intRdata (intRdata),
    .reqMatch (reqMatch),
    .rspData  (rspData),
    .intWrite (intWrite),
    .intAddr  (intAddr),
    .intBe    (intBe),
    .intWdata (intWdata)
  );

endmodule

// File: tb/tb_dtgt_top.sv
module tb_dtgt_top;

  localparam int CLK_PERIOD = 10;
  localparam int DISCARD    = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqCmd = '0;
  logic [15:0] reqAddr = '0;
  logic [3:0]  reqBe = '0;
  logic [31:0] reqWdata = '0;
  logic        rspAck, rspRetry, intStart, intWrite;
  logic [31:0] rspData, intWdata;
  logic [15:0] intAddr;
  logic [3:0]  intBe;
  logic        intDone = 1'b0;
  logic [31:0] intRdata = '0;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;
  string phaseTag = "R10";
  int memLat = 3;
  bit strayPend = 0;

  logic        gotAck, gotRetry, gotStart;
  logic [31:0] gotData;

  always #(CLK_PERIOD/2) clk = ~clk;

  dtgt_top #(.ADDR_W(16), .DATA_W(32), .FAST_REGS(4), .DISCARD_CYCLES(DISCARD)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCmd(reqCmd), .reqAddr(reqAddr),
    .reqBe(reqBe), .reqWdata(reqWdata), .rspAck(rspAck), .rspRetry(rspRetry),
    .rspData(rspData), .intStart(intStart), .intWrite(intWrite), .intAddr(intAddr),
    .intBe(intBe), .intWdata(intWdata), .intDone(intDone), .intRdata(intRdata)
  );

  function automatic logic [31:0] memData(input logic [15:0] a);
    return {a, a ^ 16'h5A5A};
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          mSlot;   // 0 empty, 1 outstanding, 2 buffered
  int          mAge;
  logic [1:0]  mCmd;
  logic [15:0] mAddr;
  logic [3:0]  mBe;
  logic [31:0] mWd, mBuf;
  logic [31:0] mFast [4];
  logic        eAck, eRetry, eStart;
  logic [31:0] eData;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSlot = 0; mAge = 0; mCmd = 0; mAddr = 0; mBe = 0; mWd = 0; mBuf = 0;
      foreach (mFast[i]) mFast[i] = 0;
      eAck = 0; eRetry = 0; eStart = 0; eData = 0;
    end else begin
      int  nxt;
      bit  served;
      bit  same;
      nxt = mSlot; served = 0;
      eAck = 0; eRetry = 0; eStart = 0; eData = 0;
      same = (reqCmd == mCmd) && (reqAddr == mAddr) && (reqBe == mBe) &&
             (mCmd != 2'b01 || reqWdata == mWd);
      if (reqValid) begin
        if (reqCmd[1]) begin
          eAck = 1;
          if (reqCmd[0] == 1'b0) eData = mFast[reqAddr[1:0]];
          else for (int b = 0; b < 4; b++)
            if (reqBe[b]) mFast[reqAddr[1:0]][b*8 +: 8] = reqWdata[b*8 +: 8];
        end else if (mSlot == 0) begin
          mCmd = reqCmd; mAddr = reqAddr; mBe = reqBe; mWd = reqWdata;
          eRetry = 1; eStart = 1; nxt = 1;
        end else if (mSlot == 2 && same) begin
          eAck = 1; eData = (mCmd == 2'b01) ? 32'h0 : mBuf;
          served = 1; nxt = 0;
        end else begin
          eRetry = 1;
        end
      end
      if (mSlot == 1 && intDone) begin mBuf = intRdata; nxt = 2; mAge = 0; end
      if (mSlot == 2 && !served) begin
        if (mAge == DISCARD - 1) nxt = 0;
        else mAge++;
      end
      mSlot = nxt;
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk("R9", "rspAck", {31'b0, rspAck}, {31'b0, eAck});
      chk("R9", "rspRetry", {31'b0, rspRetry}, {31'b0, eRetry});
      chk(phaseTag, "rspData", rspData, eData);
      chk("R1", "intStart", {31'b0, intStart}, {31'b0, eStart});
      chk("R2", "intWrite", {31'b0, intWrite}, {31'b0, mCmd[0]});
      chk("R2", "intAddr", {16'b0, intAddr}, {16'b0, mAddr});
      chk("R2", "intBe", {28'b0, intBe}, {28'b0, mBe});
      chk("R2", "intWdata", intWdata, mWd);
    end
  end

  // slow internal memory with bench-programmable latency
  initial begin
    bit          pend;
    int          cnt;
    logic [15:0] pAddr;
    pend = 0; cnt = 0; pAddr = 0;
    forever begin
      @(negedge clk);
      intDone = 0;
      intRdata = 0;
      if (strayPend) begin
        intDone = 1; intRdata = 32'hDEAD_BEEF; strayPend = 0;
      end else if (pend) begin
        if (cnt == 0) begin
          intDone = 1; intRdata = memData(pAddr); pend = 0;
        end else cnt--;
      end
      if (intStart && rstN) begin
        pend = 1; cnt = memLat - 1; pAddr = intAddr;
      end
    end
  end

  task automatic doReq(input logic [1:0] c, input logic [15:0] a, input logic [3:0] be, input logic [31:0] wd);
    @(negedge clk);
    reqValid = 1; reqCmd = c; reqAddr = a; reqBe = be; reqWdata = wd;
    @(negedge clk);
    gotAck = rspAck; gotRetry = rspRetry; gotData = rspData; gotStart = intStart;
    reqValid = 0;
  endtask

  task automatic waitDone();
    repeat (memLat + 4) @(negedge clk);
  endtask

  task automatic finishRun();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk("R10", "rspAck", {31'b0, rspAck}, 32'h0);
    chk("R10", "rspRetry", {31'b0, rspRetry}, 32'h0);
    chk("R10", "intStart", {31'b0, intStart}, 32'h0);
    chk("R10", "intAddr", {16'b0, intAddr}, 32'h0);
    rstN = 1;
    repeat (2) @(negedge clk);

    // R1: first slow read is recorded and retried; long latency
    phaseTag = "R1"; memLat = 12;
    doReq(2'b00, 16'h0100, 4'hF, 32'h0);
    chk("R1", "retry on first read", {31'b0, gotRetry}, 32'h1);
    chk("R1", "start pulse", {31'b0, gotStart}, 32'h1);
    chk("R1", "intAddr", {16'b0, intAddr}, 32'h0100);
    // R6: identical repeat while outstanding is retried
    phaseTag = "R6";
    doReq(2'b00, 16'h0100, 4'hF, 32'h0);
    chk("R6", "retry while busy", {31'b0, gotRetry}, 32'h1);
    chk("R6", "no start while busy", {31'b0, gotStart}, 32'h0);
    waitDone();
    // R6: different request after buffering is retried, not recorded
    doReq(2'b00, 16'h0200, 4'hF, 32'h0);
    chk("R6", "retry non-matching", {31'b0, gotRetry}, 32'h1);
    chk("R6", "no start non-matching", {31'b0, gotStart}, 32'h0);
    chk("R6", "recorded addr kept", {16'b0, intAddr}, 32'h0100);
    // R7: register bank served while slot is held
    phaseTag = "R7";
    doReq(2'b11, 16'h0001, 4'hF, 32'h1122_3344);
    chk("R7", "reg write ack", {31'b0, gotAck}, 32'h1);
    doReq(2'b11, 16'h0001, 4'b0101, 32'hAABB_CCDD);
    doReq(2'b10, 16'h0001, 4'hF, 32'h0);
    chk("R7", "reg read merged bytes", gotData, 32'h11BB_33DD);
    doReq(2'b10, 16'h0002, 4'hF, 32'h0);
    chk("R7", "other reg untouched", gotData, 32'h0);
    // R5: differing byte enables do not match
    phaseTag = "R5";
    doReq(2'b00, 16'h0100, 4'h3, 32'h0);
    chk("R5", "be mismatch retried", {31'b0, gotRetry}, 32'h1);
    // R5: read ignores write data; R4 delivery
    phaseTag = "R4";
    doReq(2'b00, 16'h0100, 4'hF, 32'h7777_0000);
    chk("R4", "matching read acked", {31'b0, gotAck}, 32'h1);
    chk("R4", "buffered read data", gotData, memData(16'h0100));
    chk("R5", "read wdata ignored", {31'b0, gotRetry}, 32'h0);

    // R4: slot free again; slow write with short latency
    memLat = 3; phaseTag = "R4";
    doReq(2'b01, 16'h0300, 4'hC, 32'hCAFE_F00D);
    chk("R4", "new record after delivery", {31'b0, gotStart}, 32'h1);
    chk("R1", "intWrite for write", {31'b0, intWrite}, 32'h1);
    waitDone();
    phaseTag = "R5";
    doReq(2'b01, 16'h0300, 4'hC, 32'hCAFE_F00E);
    chk("R5", "write data mismatch retried", {31'b0, gotRetry}, 32'h1);
    doReq(2'b01, 16'h0300, 4'hC, 32'hCAFE_F00D);
    chk("R4", "matching write acked", {31'b0, gotAck}, 32'h1);
    chk("R4", "write ack data zero", gotData, 32'h0);

    // R3: stray completion in buffered state is ignored
    phaseTag = "R3";
    doReq(2'b00, 16'h0500, 4'hF, 32'h0);
    waitDone();
    strayPend = 1;
    repeat (3) @(negedge clk);
    doReq(2'b00, 16'h0500, 4'hF, 32'h0);
    chk("R3", "stray done ignored", gotData, memData(16'h0500));

    // R8: discard after timeout, then recorded anew
    phaseTag = "R8";
    doReq(2'b00, 16'h0400, 4'hF, 32'h0);
    waitDone();
    repeat (DISCARD + 5) @(negedge clk);
    doReq(2'b00, 16'h0400, 4'hF, 32'h0);
    chk("R8", "expired slot retried", {31'b0, gotRetry}, 32'h1);
    chk("R8", "expired slot recorded anew", {31'b0, gotStart}, 32'h1);
    waitDone();
    doReq(2'b00, 16'h0400, 4'hF, 32'h0);
    chk("R8", "fresh result delivered", gotData, memData(16'h0400));

    // R9: idle cycles give no response
    phaseTag = "R9";
    repeat (4) @(negedge clk);
    chk("R9", "idle no ack", {31'b0, rspAck}, 32'h0);
    finishRun();
  end

endmodule